// File: doc/BRIEF.md
# Prescaled Up-Counting Event Timer

This block is a small timer peripheral for use behind a simple synchronous register bus. A clock divider produces a count tick once every (divider limit + 1) clock cycles. An up-counter advances on each tick. When it reaches its programmed ceiling it wraps to zero and raises an update event. The event sets a sticky status flag. That flag drives a level interrupt through an enable bit and, through a second enable, a single-cycle request pulse for a transfer engine.

Software writes the divider limit and the ceiling into holding registers. The running copies take those values only on an update event. An update event is either a counter wrap or a software-requested update. A software update also restarts the counter and the divider. A control bit lets software updates reload the running copies without touching the status flag. The bus reads combinationally: `bus_rdata` reflects the register at `bus_addr` in the same cycle. A write takes effect at the next rising clock edge.

Top module: `basic_tick_timer`

## Requirements
- R1: After reset, every register reads 0, `irq_o` and `dma_req_o` are low, and both the running divider limit and the running ceiling are 0.
- R2: Register map. Offset 0x00 is control: bit 0 is run and bit 2 is wrap-only-flag. Offset 0x0C is enables: bit 0 is the interrupt enable and bit 8 is the request enable. Offset 0x10 is status: bit 0 is the flag. Offset 0x28 is the divider limit holding register and offset 0x2C is the ceiling holding register, both 16 bits. Unused bits read 0. Offset 0x14 is write-only and reads 0, and every other offset reads 0.
- R3: While run is 1, the count at offset 0x24 (bits 15:0) rises by one every (running divider limit + 1) clock cycles.
- R4: A tick that arrives while the count equals the running ceiling returns the count to 0, sets the flag and forms an update event.
- R5: Writes to 0x28 and 0x2C reach the running copies only at the next update event.
- R6: Writing 1 to bit 0 of offset 0x14 is a software update. It zeroes the count and the divider and loads the running copies. The bit never reads back as 1.
- R7: A software update sets the flag only while the wrap-only-flag bit is 0.
- R8: Writing 0 to status bit 0 clears the flag and writing 1 leaves it unchanged. A flag set in the same cycle as a clear wins.
- R9: `irq_o` is 1 exactly while the flag and the interrupt enable are both 1.
- R10: `dma_req_o` is high for one cycle after each flag-setting update event that occurs while the request enable is 1. It is high in the first cycle in which the flag reads 1.
- R11: Offset 0x24 reads the count in bits 15:0 and the flag in bit 31. Writing it loads bits 15:0 into the count, and this write takes priority over a tick in the same cycle.
- R12: While run is 0, the count and the divider hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq_o | output | 1 | Level interrupt request |
| dma_req_o | output | 1 | Single-cycle transfer request pulse |

## Verification
The bench targets four corner cases. The first is a ceiling of 0 with a divider limit of 0, where the timer wraps on every cycle. A design that mishandles it freezes the count or drops flag sets. The second is a status clear issued while a wrap is under way; a design that lets the clear win loses an event. The third is a software update with the wrap-only-flag bit set; a wrong design raises a spurious interrupt or request pulse. The fourth is holding-register writes made between events. A design that passes them straight to the running copies changes the tick period in mid-period, and a design that ignores a software update keeps the old period. Random register traffic is mixed with these directed phases and compared each cycle with a model derived from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    parameter int unsigned TMR_ADDR_W = 8;

    localparam logic [TMR_ADDR_W-1:0] OFF_CTRL = 8'h00;
    localparam logic [TMR_ADDR_W-1:0] OFF_IEN  = 8'h0C;
    localparam logic [TMR_ADDR_W-1:0] OFF_STAT = 8'h10;
    localparam logic [TMR_ADDR_W-1:0] OFF_EGR  = 8'h14;
    localparam logic [TMR_ADDR_W-1:0] OFF_CNT  = 8'h24;
    localparam logic [TMR_ADDR_W-1:0] OFF_PSC  = 8'h28;
    localparam logic [TMR_ADDR_W-1:0] OFF_ARR  = 8'h2C;

    localparam int unsigned BIT_RUN      = 0;
    localparam int unsigned BIT_OVF_ONLY = 2;
    localparam int unsigned BIT_UIE      = 0;
    localparam int unsigned BIT_DMAE     = 8;
    localparam int unsigned BIT_FLAG     = 0;
    localparam int unsigned BIT_SWUPD    = 0;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_IEN,
        SEL_STAT,
        SEL_EGR,
        SEL_CNT,
        SEL_PSC,
        SEL_ARR,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [TMR_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_CTRL: s = SEL_CTRL;
            OFF_IEN:  s = SEL_IEN;
            OFF_STAT: s = SEL_STAT;
            OFF_EGR:  s = SEL_EGR;
            OFF_CNT:  s = SEL_CNT;
            OFF_PSC:  s = SEL_PSC;
            OFF_ARR:  s = SEL_ARR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             load,
    input  logic [PSC_W-1:0] psc_pre,
    output logic             tick
);

    typedef struct packed {
        logic [PSC_W-1:0] div;
        logic [PSC_W-1:0] lim;
    } psc_state_t;

    psc_state_t s_d, s_q;

    // one tick at the end of each (lim + 1)-cycle window
    assign tick = run && (s_q.div == s_q.lim);

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.div = '0;
        end else if (run) begin
            s_d.div = tick ? '0 : s_q.div + 1'b1;
        end
        if (load) begin
            s_d.lim = psc_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             load,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] lim_pre,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    assign cnt  = s_q.cnt;
    assign wrap = tick && (s_q.cnt == s_q.lim);

    // priority: software restart, bus load, wrap, plain step
    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (wr_en) begin
            s_d.cnt = wr_val;
        end else if (wrap) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (load) begin
            s_d.lim = lim_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PSC_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TMR_ADDR_W-1:0] addr,
    input  logic                  we,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [CNT_W-1:0]      cnt,
    input  logic                  wrap,
    output logic                  run,
    output logic                  swupd,
    output logic                  cnt_wr,
    output logic [CNT_W-1:0]      cnt_wr_val,
    output logic [PSC_W-1:0]      psc_pre,
    output logic [CNT_W-1:0]      arr_pre,
    output logic                  flag,
    output logic [DATA_W-1:0]     rdata,
    output logic                  irq,
    output logic                  dma
);

    typedef struct packed {
        logic             run;
        logic             ovf_only;
        logic             uie;
        logic             dmae;
        logic             flag;
        logic             dma;
        logic [PSC_W-1:0] psc_pre;
        logic [CNT_W-1:0] arr_pre;
    } reg_state_t;

    reg_state_t r_d, r_q;
    reg_sel_e   sel;
    logic       flag_set;
    logic       unused_wdata;

    assign unused_wdata = ^wdata;

    assign sel        = decode_sel(addr);
    assign swupd      = we && (sel == SEL_EGR) && wdata[BIT_SWUPD];
    assign cnt_wr     = we && (sel == SEL_CNT);
    assign cnt_wr_val = wdata[CNT_W-1:0];
    assign flag_set   = wrap || (swupd && !r_q.ovf_only);

    always_comb begin
        r_d     = r_q;
        r_d.dma = flag_set && r_q.dmae;
        if (we) begin
            case (sel)
                SEL_CTRL: begin
                    r_d.run      = wdata[BIT_RUN];
                    r_d.ovf_only = wdata[BIT_OVF_ONLY];
                end
                SEL_IEN: begin
                    r_d.uie  = wdata[BIT_UIE];
                    r_d.dmae = wdata[BIT_DMAE];
                end
                SEL_STAT: begin
                    if (!wdata[BIT_FLAG]) begin
                        r_d.flag = 1'b0;
                    end
                end
                SEL_PSC: r_d.psc_pre = wdata[PSC_W-1:0];
                SEL_ARR: r_d.arr_pre = wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        // a set in the same cycle overrides a clear
        if (flag_set) begin
            r_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_CTRL: begin
                rdata[BIT_RUN]      = r_q.run;
                rdata[BIT_OVF_ONLY] = r_q.ovf_only;
            end
            SEL_IEN: begin
                rdata[BIT_UIE]  = r_q.uie;
                rdata[BIT_DMAE] = r_q.dmae;
            end
            SEL_STAT: rdata[BIT_FLAG] = r_q.flag;
            SEL_CNT: begin
                rdata[CNT_W-1:0] = cnt;
                rdata[DATA_W-1]  = r_q.flag;
            end
            SEL_PSC: rdata[PSC_W-1:0] = r_q.psc_pre;
            SEL_ARR: rdata[CNT_W-1:0] = r_q.arr_pre;
            default: rdata = '0;
        endcase
    end

    assign run     = r_q.run;
    assign psc_pre = r_q.psc_pre;
    assign arr_pre = r_q.arr_pre;
    assign flag    = r_q.flag;
    assign irq     = r_q.flag && r_q.uie;
    assign dma     = r_q.dma;

endmodule

// File: rtl/basic_tick_timer.sv
module basic_tick_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PSC_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TMR_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_o,
    output logic                  dma_req_o
);

    logic             run_w;
    logic             swupd_w;
    logic             cnt_wr_w;
    logic [CNT_W-1:0] cnt_wr_val_w;
    logic [PSC_W-1:0] psc_pre_w;
    logic [CNT_W-1:0] arr_pre_w;
    logic             tick_w;
    logic             wrap_w;
    logic [CNT_W-1:0] cnt_w;
    logic             flag_w;
    logic             upd_w;

    // either update source reloads both running copies
    assign upd_w = wrap_w || swupd_w;

    tmr_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .PSC_W  (PSC_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .we         (bus_we),
        .wdata      (bus_wdata),
        .cnt        (cnt_w),
        .wrap       (wrap_w),
        .run        (run_w),
        .swupd      (swupd_w),
        .cnt_wr     (cnt_wr_w),
        .cnt_wr_val (cnt_wr_val_w),
        .psc_pre    (psc_pre_w),
        .arr_pre    (arr_pre_w),
        .flag       (flag_w),
        .rdata      (bus_rdata),
        .irq        (irq_o),
        .dma        (dma_req_o)
    );

    tmr_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .restart (swupd_w),
        .load    (upd_w),
        .psc_pre (psc_pre_w),
        .tick    (tick_w)
    );

    tmr_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .restart (swupd_w),
        .load    (upd_w),
        .wr_en   (cnt_wr_w),
        .wr_val  (cnt_wr_val_w),
        .lim_pre (arr_pre_w),
        .cnt     (cnt_w),
        .wrap    (wrap_w)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wrap,
    input logic             swupd,
    input logic             cnt_wr,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             irq,
    input logic             dma
);

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !swupd && !cnt_wr) |=> (cnt == '0));

    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap && !swupd && !cnt_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !swupd && !cnt_wr) |=> $stable(cnt));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swupd |=> (cnt == '0));

    // R9
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R10
    dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma |-> flag);

endmodule

bind basic_tick_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_w),
    .wrap   (wrap_w),
    .swupd  (swupd_w),
    .cnt_wr (cnt_wr_w),
    .run    (run_w),
    .cnt    (cnt_w),
    .flag   (flag_w),
    .irq    (irq_o),
    .dma    (dma_req_o)
);

// File: tb/basic_tick_timer_bench.sv
module basic_tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        dma_req_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // model state, built from the requirements
    logic        m_run, m_oo, m_uie, m_dmae, m_flag, m_dma;
    logic [15:0] m_psc_pre, m_arr_pre, m_psc_act, m_arr_act, m_div, m_cnt;

    always #5 clk = ~clk;

    basic_tick_timer u_basic_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .dma_req_o (dma_req_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_run = 0; m_oo = 0; m_uie = 0; m_dmae = 0; m_flag = 0; m_dma = 0;
        m_psc_pre = 0; m_arr_pre = 0; m_psc_act = 0; m_arr_act = 0; m_div = 0; m_cnt = 0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        case (a)
            8'h00: begin r[0] = m_run; r[2] = m_oo; end
            8'h0C: begin r[0] = m_uie; r[8] = m_dmae; end
            8'h10: r[0] = m_flag;
            8'h24: begin r[15:0] = m_cnt; r[31] = m_flag; end
            8'h28: r[15:0] = m_psc_pre;
            8'h2C: r[15:0] = m_arr_pre;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        return (a == 8'h24) ? "R11" : "R2";
    endfunction

    task automatic model_step(input logic [7:0] a, input logic we, input logic [31:0] d);
        logic sw, tk, wr, st;
        logic [15:0] div_n, cnt_n;
        sw = we && a == 8'h14 && d[0];
        tk = m_run && (m_div == m_psc_act);
        wr = tk && (m_cnt == m_arr_act);
        st = wr || (sw && !m_oo);
        div_n = sw ? 16'h0 : (m_run ? (tk ? 16'h0 : m_div + 16'h1) : m_div);
        if (sw) cnt_n = 0;
        else if (we && a == 8'h24) cnt_n = d[15:0];
        else if (wr) cnt_n = 0;
        else if (tk) cnt_n = m_cnt + 16'h1;
        else cnt_n = m_cnt;
        if (wr || sw) begin m_psc_act = m_psc_pre; m_arr_act = m_arr_pre; end
        m_dma = st && m_dmae;
        if (we && a == 8'h10 && !d[0]) m_flag = 0;
        if (st) m_flag = 1;
        if (we) begin
            case (a)
                8'h00: begin m_run = d[0]; m_oo = d[2]; end
                8'h0C: begin m_uie = d[0]; m_dmae = d[8]; end
                8'h28: m_psc_pre = d[15:0];
                8'h2C: m_arr_pre = d[15:0];
                default: ;
            endcase
        end
        m_div = div_n;
        m_cnt = cnt_n;
    endtask

    // one bus cycle: drive, compare against the model, advance the model
    task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] d, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = d;
        #1;
        chk((tag == "") ? tag_of(a) : tag, bus_rdata, exp_rd(a));
        chk("R9", {31'b0, irq_o}, {31'b0, m_flag && m_uie});
        chk("R10", {31'b0, dma_req_o}, {31'b0, m_dma});
        model_step(a, we, d);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        cyc(a, 1'b1, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(a, 1'b0, 32'h0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] offs [10];
        offs = '{8'h00, 8'h0C, 8'h10, 8'h14, 8'h24, 8'h28, 8'h2C, 8'h04, 8'h30, 8'h25};
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values, compared to hard zeros too
        for (int i = 0; i < 10; i++) begin
            cyc(offs[i], 1'b0, 32'h0, "R1");
            chk("R1", bus_rdata, 32'h0);
        end
        chk("R1", {30'b0, irq_o, dma_req_o}, 32'h0);

        // R2: field placement and masking
        wr(8'h00, 32'h0000_0004, "R2");
        rd(8'h00, 1, "R2");
        chk("R2", bus_rdata, 32'h4);
        wr(8'h0C, 32'hFFFF_FFFF, "R2");
        rd(8'h0C, 1, "R2");
        chk("R2", bus_rdata, 32'h101);
        wr(8'h0C, 32'h0, "R2");
        wr(8'h00, 32'h0, "R2");
        wr(8'h04, 32'hFFFF_FFFF, "R2");
        rd(8'h04, 1, "R2");
        rd(8'h14, 1, "R2");

        // R5: holding values do not reach the running copies early
        wr(8'h28, 32'h0001_0001, "R5");
        wr(8'h2C, 32'h0000_0004, "R5");
        rd(8'h28, 1, "R5");
        chk("R5", bus_rdata, 32'h1);
        wr(8'h00, 32'h1, "R5");
        rd(8'h24, 12, "R5");

        // R6: software restart
        wr(8'h14, 32'h1, "R6");
        rd(8'h24, 1, "R6");
        chk("R6", bus_rdata & 32'hFFFF, 32'h0);
        rd(8'h24, 6, "R6");

        // R3: divide by three
        wr(8'h28, 32'h2, "R3");
        wr(8'h2C, 32'hFFFF, "R3");
        wr(8'h14, 32'h1, "R3");
        rd(8'h24, 13, "R3");

        // R12: stopped counter holds
        wr(8'h00, 32'h0, "R12");
        rd(8'h24, 8, "R12");

        // R7: wrap-only-flag bit gates software updates
        wr(8'h10, 32'h0, "R7");
        wr(8'h00, 32'h4, "R7");
        wr(8'h14, 32'h1, "R7");
        rd(8'h10, 1, "R7");
        chk("R7", bus_rdata, 32'h0);
        wr(8'h00, 32'h0, "R7");
        wr(8'h14, 32'h1, "R7");
        rd(8'h10, 1, "R7");
        chk("R7", bus_rdata, 32'h1);

        // R4: wrap at ceiling 3, every cycle
        wr(8'h10, 32'h0, "R4");
        wr(8'h28, 32'h0, "R4");
        wr(8'h2C, 32'h3, "R4");
        wr(8'h14, 32'h1, "R4");
        wr(8'h10, 32'h0, "R4");
        wr(8'h00, 32'h1, "R4");
        rd(8'h24, 10, "R4");

        // R8: write 1 keeps, write 0 clears, set beats clear
        wr(8'h00, 32'h0, "R8");
        wr(8'h10, 32'h1, "R8");
        rd(8'h10, 1, "R8");
        chk("R8", bus_rdata, 32'h1);
        wr(8'h10, 32'h0, "R8");
        rd(8'h10, 1, "R8");
        chk("R8", bus_rdata, 32'h0);
        wr(8'h2C, 32'h0, "R8");
        wr(8'h14, 32'h1, "R8");
        wr(8'h00, 32'h1, "R8");
        wr(8'h10, 32'h0, "R8");
        rd(8'h10, 1, "R8");
        chk("R8", bus_rdata, 32'h1);

        // R9/R10: interrupt level and request pulses
        wr(8'h00, 32'h0, "R10");
        wr(8'h2C, 32'h2, "R10");
        wr(8'h14, 32'h1, "R10");
        wr(8'h10, 32'h0, "R10");
        wr(8'h0C, 32'h101, "R10");
        wr(8'h00, 32'h1, "R10");
        rd(8'h10, 9, "R10");
        wr(8'h0C, 32'h1, "R9");
        rd(8'h10, 4, "R9");

        // R11: count load and flag mirror
        wr(8'h00, 32'h0, "R11");
        wr(8'h24, 32'hABCD_1234, "R11");
        rd(8'h24, 1, "R11");
        chk("R11", bus_rdata, 32'h8000_1234);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic        w;
            a = offs[$urandom_range(0, 9)];
            w = ($urandom_range(0, 9) < 3);
            d = $urandom();
            if (a == 8'h28 || a == 8'h2C) d = d & 32'h7;
            if (a == 8'h24) d = d & 32'h3;
            cyc(a, w, d, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule